// File: doc/BRIEF.md
# Alternating-Slot Shared RAM Arbiter

This block lets a host port and an on-board processor port share one single-ported word RAM as if it had two ports. The block runs on the bus clock. It divides that clock by two to form on-board slots of two bus cycles each. Slots go to the host and to the processor in strict turn. The RAM operation of a slot takes place on the last edge of that slot. No request-based arbitration is used. The processor sees its slot on `proc_grant` and drives its request during that cycle.

A host request is taken into a data-port register when the next host slot opens. The register holds the address, direction and write data unchanged for the whole slot. The host receives a one-cycle acknowledge in the bus cycle after the slot ends. Read data comes from the RAM's own output register and is not registered again. Access rights differ by region. The bottom sixteenth of the RAM can be written only by the host. Host accesses to the top `SHADOW_WORDS` words never reach the RAM; they go to a select window for the processor's internal registers. While the processor is held in reset, every slot goes to the host. When the hold is released, the block gives the processor a start pulse together with its start address. The defaults give a 4K-word RAM. Setting `AW`=15 gives the full 32K x 32 configuration, with 2048 host-only words.

Top module: `shared_ram_arbiter`

## Requirements
- R1: A host write to a RAM word followed by a host read of the same word returns the written 32-bit value. This holds for every word below the shadow window.
- R2: When not held, slot ownership alternates host, processor, host, and so on. Each slot lasts two bus cycles. `proc_grant` is high only in the second cycle of a processor slot, which is one cycle in every four, never two cycles in a row. A RAM operation happens only at the end of a slot.
- R3: A processor write to a word below `PROT_WORDS` (default 256) leaves the RAM unchanged. A processor write at or above that word updates the RAM.
- R4: A host access with a word address at or above `2**AW - SHADOW_WORDS` (default 4080..4095) does not touch the RAM. During the slot it drives `shadow_sel` and `shadow_idx` (the low address bits), plus `shadow_we` and `shadow_wdata` for a write. A shadow read returns the value on `shadow_rdata`.
- R5: A host request is captured at the start of the next host slot. `host_ack` is high for exactly one cycle, in the bus cycle right after that slot. A request made in the last cycle of a processor slot sees `host_ack` 3 cycles later, and no request waits more than 6 cycles.
- R6: After capture, changes on `host_wdata` have no effect on the word that is written.
- R7: While `proc_hold` is high, all slots are host slots. `proc_grant` stays low, and processor write requests do not change the RAM.
- R8: On the cycle after `proc_hold` falls, `proc_start` pulses for one cycle. `proc_start_addr` is `START_ADDR` (default word 0).
- R9: After reset, `host_ack`, `proc_grant`, `proc_start` and `shadow_sel` are low.
- R10: A processor read issued in its slot presents the RAM word on `proc_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_hold | input | 1 | Holds the processor in reset; all slots go to the host |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host write when high |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Host read data, valid while host_ack is high |
| proc_en | input | 1 | Processor access request in its granted cycle |
| proc_we | input | 1 | Processor write when high |
| proc_addr | input | AW | Processor word address |
| proc_wdata | input | DW | Processor write data |
| proc_rdata | output | DW | Processor read data, valid the cycle after its slot |
| proc_grant | output | 1 | Last cycle of a processor slot |
| proc_start | output | 1 | Pulse after release of the hold |
| proc_start_addr | output | AW | Processor start address |
| shadow_sel | output | 1 | Host access targets the register window |
| shadow_we | output | 1 | Host write into the register window |
| shadow_idx | output | SHW | Register index within the window |
| shadow_wdata | output | DW | Write data for the register window |
| shadow_rdata | input | DW | Read data from the register window |

## Verification
The assertions check several properties on every cycle. RAM operations fall only on slot boundaries. The grant never repeats on adjacent cycles and stays off through a sustained hold. No processor write reaches the host-only region, and no host operation reaches the RAM inside the shadow window. The acknowledge is a single pulse after a slot end, and the start pulse follows a falling hold. Other behaviour can only be shown by the bench scenarios: data integrity across the two ports, the exact acknowledge latency, the fact that the data-port register ignores late data changes, and the effects of ignored processor writes.

// File: rtl/shared_ram_pkg.sv
`timescale 1ns/1ps
package shared_ram_pkg;
  typedef enum logic {SLOT_HOST = 1'b0, SLOT_PROC = 1'b1} slot_owner_t;
endpackage

// File: rtl/sram_sp.sv
`timescale 1ns/1ps
module sram_sp #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q <= mem[addr];
    end
  end
endmodule

// File: rtl/slot_timer.sv
`timescale 1ns/1ps
module slot_timer
  import shared_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        proc_hold,
  output slot_owner_t owner,
  output slot_owner_t next_owner,
  output logic        slot_end
);
  logic ph;

  assign slot_end   = ph;
  assign next_owner = (proc_hold || owner == SLOT_PROC) ? SLOT_HOST : SLOT_PROC;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= 1'b0;
      owner <= SLOT_HOST;
    end else begin
      ph <= ~ph;
      if (ph) owner <= next_owner;
    end
  end
endmodule

// File: rtl/host_dport.sv
`timescale 1ns/1ps
module host_dport
  import shared_ram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int SHADOW_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_end,
  input  slot_owner_t   next_owner,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          active,
  output logic          hit,
  output logic          we_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q,
  output logic          ack
);
  localparam logic [AW-1:0] SHADOW_BASE = AW'((1 << AW) - SHADOW_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ack    <= 1'b0;
      hit    <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ack <= slot_end && active;
      if (slot_end) begin
        if (active) begin
          active <= 1'b0;
        end else if (next_owner == SLOT_HOST && host_req) begin
          active <= 1'b1;
          we_q   <= host_we;
          addr_q <= host_addr;
          data_q <= host_wdata;
          hit    <= (host_addr >= SHADOW_BASE);
        end
      end
    end
  end
endmodule

// File: rtl/shared_ram_arbiter.sv
`timescale 1ns/1ps
module shared_ram_arbiter
  import shared_ram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int SHADOW_WORDS = 16,
  parameter int PROT_WORDS = (1 << AW) / 16,
  parameter int START_ADDR = 0,
  localparam int SHW = $clog2(SHADOW_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           proc_hold,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic           host_ack,
  output logic [DW-1:0]  host_rdata,
  input  logic           proc_en,
  input  logic           proc_we,
  input  logic [AW-1:0]  proc_addr,
  input  logic [DW-1:0]  proc_wdata,
  output logic [DW-1:0]  proc_rdata,
  output logic           proc_grant,
  output logic           proc_start,
  output logic [AW-1:0]  proc_start_addr,
  output logic           shadow_sel,
  output logic           shadow_we,
  output logic [SHW-1:0] shadow_idx,
  output logic [DW-1:0]  shadow_wdata,
  input  logic [DW-1:0]  shadow_rdata
);
  localparam logic [AW-1:0] PROT_LIMIT = AW'(PROT_WORDS);

  slot_owner_t   owner, next_owner;
  logic          slot_end;
  logic          h_active, h_hit, h_we;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_data;
  logic          host_op, proc_op;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;
  logic          hold_q, start_q;
  logic          sel_shd;
  logic [DW-1:0] shd_q;

  slot_timer u_timer (
    .clk(clk), .rst(rst), .proc_hold(proc_hold),
    .owner(owner), .next_owner(next_owner), .slot_end(slot_end)
  );

  host_dport #(.AW(AW), .DW(DW), .SHADOW_WORDS(SHADOW_WORDS)) u_dport (
    .clk(clk), .rst(rst), .slot_end(slot_end), .next_owner(next_owner),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .active(h_active), .hit(h_hit), .we_q(h_we),
    .addr_q(h_addr), .data_q(h_data), .ack(host_ack)
  );

  assign host_op = slot_end && owner == SLOT_HOST && h_active && !h_hit;
  assign proc_op = slot_end && owner == SLOT_PROC && !proc_hold && proc_en;

  always_comb begin
    ram_en    = host_op || proc_op;
    ram_we    = 1'b0;
    ram_addr  = proc_addr;
    ram_wdata = proc_wdata;
    if (host_op) begin
      ram_we    = h_we;
      ram_addr  = h_addr;
      ram_wdata = h_data;
    end else if (proc_op) begin
      ram_we = proc_we && (proc_addr >= PROT_LIMIT);
    end
  end

  sram_sp #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b1;
      start_q <= 1'b0;
      sel_shd <= 1'b0;
      shd_q   <= '0;
    end else begin
      hold_q  <= proc_hold;
      start_q <= hold_q && !proc_hold;
      if (slot_end && h_active) begin
        sel_shd <= h_hit;
        if (h_hit) shd_q <= shadow_rdata;
      end
    end
  end

  assign host_rdata      = sel_shd ? shd_q : ram_q;
  assign proc_rdata      = ram_q;
  assign proc_grant      = (owner == SLOT_PROC) && slot_end;
  assign proc_start      = start_q;
  assign proc_start_addr = AW'(START_ADDR);
  assign shadow_sel      = h_active && h_hit;
  assign shadow_we       = h_active && h_hit && h_we;
  assign shadow_idx      = h_addr[SHW-1:0];
  assign shadow_wdata    = h_data;
endmodule

// File: rtl/shared_ram_arbiter_chk.sv
`timescale 1ns/1ps
module shared_ram_arbiter_chk #(
  parameter int AW = 12,
  parameter int SHADOW_WORDS = 16,
  parameter int PROT_WORDS = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          proc_hold,
  input logic          proc_grant,
  input logic          host_ack,
  input logic          proc_start,
  input logic          slot_end,
  input logic          owner_proc,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr
);
  localparam logic [AW-1:0] PROT_A = AW'(PROT_WORDS);
  localparam logic [AW-1:0] SHB_A  = AW'((1 << AW) - SHADOW_WORDS);

  AST_RAM_ON_SLOT_END: assert property (@(posedge clk) disable iff (rst) ram_en |-> slot_end); // R2
  AST_GRANT_ALTERNATES: assert property (@(posedge clk) disable iff (rst) proc_grant |=> !proc_grant); // R2
  AST_LOW_REGION_GUARD: assert property (@(posedge clk) disable iff (rst) (ram_en && ram_we && owner_proc) |-> ram_addr >= PROT_A); // R3
  AST_SHADOW_NO_RAM: assert property (@(posedge clk) disable iff (rst) (ram_en && !owner_proc) |-> ram_addr < SHB_A); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) host_ack |=> !host_ack); // R5
  AST_ACK_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst) host_ack |-> $past(slot_end)); // R5
  AST_HOLD_NO_GRANT: assert property (@(posedge clk) disable iff (rst) (proc_hold && $past(proc_hold) && $past(proc_hold, 2)) |-> !proc_grant); // R7
  AST_START_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst) proc_start |-> ($past(proc_hold, 2) && !$past(proc_hold))); // R8
endmodule

bind shared_ram_arbiter shared_ram_arbiter_chk #(
  .AW(AW), .SHADOW_WORDS(SHADOW_WORDS), .PROT_WORDS(PROT_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .proc_hold(proc_hold), .proc_grant(proc_grant),
  .host_ack(host_ack), .proc_start(proc_start), .slot_end(slot_end),
  .owner_proc(owner == shared_ram_pkg::SLOT_PROC), .ram_en(ram_en),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/sim_shared_ram_arbiter.sv
`timescale 1ns/1ps
module sim_shared_ram_arbiter;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int SHW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proc_hold = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ack;
  logic [DW-1:0] host_rdata;
  logic proc_en = 1'b0, proc_we = 1'b0;
  logic [AW-1:0] proc_addr = '0;
  logic [DW-1:0] proc_wdata = '0;
  logic [DW-1:0] proc_rdata;
  logic proc_grant, proc_start;
  logic [AW-1:0] proc_start_addr;
  logic shadow_sel, shadow_we;
  logic [SHW-1:0] shadow_idx;
  logic [DW-1:0] shadow_wdata;
  logic [DW-1:0] shadow_rdata = 32'hC0DE_5A5A;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] rd;
  int lat;
  bit shw;

  always #4 clk = ~clk;

  shared_ram_arbiter u0 (
    .clk(clk), .rst(rst), .proc_hold(proc_hold),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .proc_en(proc_en), .proc_we(proc_we), .proc_addr(proc_addr),
    .proc_wdata(proc_wdata), .proc_rdata(proc_rdata), .proc_grant(proc_grant),
    .proc_start(proc_start), .proc_start_addr(proc_start_addr),
    .shadow_sel(shadow_sel), .shadow_we(shadow_we), .shadow_idx(shadow_idx),
    .shadow_wdata(shadow_wdata), .shadow_rdata(shadow_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_grant();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (proc_grant) return;
    end
    check(1'b0, "R2 grant timeout", 0, 1);
  endtask

  task automatic host_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit sync, input bit corrupt,
                         output logic [DW-1:0] r, output int l, output bit sw);
    if (sync) wait_grant();
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    l = 0; sw = 1'b0; r = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      l++;
      if (corrupt) host_wdata = ~d;
      if (shadow_we && shadow_idx == a[SHW-1:0] && shadow_wdata == d) sw = 1'b1;
      if (host_ack) break;
    end
    if (!host_ack) check(1'b0, "R5 ack timeout", 0, 1);
    r = host_rdata;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic proc_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] r);
    wait_grant();
    proc_en = 1'b1; proc_we = we; proc_addr = a; proc_wdata = d;
    @(negedge clk);
    r = proc_rdata;
    proc_en = 1'b0; proc_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(host_ack == 0 && proc_grant == 0 && proc_start == 0 && shadow_sel == 0,
          "R9 reset outputs", {host_ack, proc_grant, proc_start, shadow_sel}, 0);
  endtask

  task automatic t_hold();
    int g = 0;
    host_op(1, 12'h005, 32'h1111_2222, 0, 0, rd, lat, shw);
    check(lat >= 3 && lat <= 6, "R5 latency under hold", lat, 3);
    proc_en = 1; proc_we = 1; proc_addr = 12'h005; proc_wdata = 32'hDEAD_0005;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (proc_grant) g++;
    end
    proc_en = 0; proc_we = 0;
    check(g == 0, "R7 no grant while held", g, 0);
    host_op(0, 12'h005, 0, 0, 0, rd, lat, shw);
    check(rd == 32'h1111_2222, "R7 held proc write ignored", rd, 32'h1111_2222);
  endtask

  task automatic t_boot();
    @(negedge clk);
    proc_hold = 1'b0;
    @(negedge clk);
    check(proc_start == 1, "R8 start pulse", proc_start, 1);
    check(proc_start_addr == 0, "R8 start address", proc_start_addr, 0);
    @(negedge clk);
    check(proc_start == 0, "R8 start pulse width", proc_start, 0);
  endtask

  task automatic t_slots();
    int g = 0;
    bit prev = 0, dbl = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (proc_grant) g++;
      if (proc_grant && prev) dbl = 1;
      prev = proc_grant;
    end
    check(g == 10, "R2 one grant per four cycles", g, 10);
    check(!dbl, "R2 grant never back to back", dbl, 0);
  endtask

  task automatic t_host_rw();
    logic [DW-1:0] pat [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1357_9BDF};
    logic [AW-1:0] adr [4] = '{12'h100, 12'hFEF, 12'h0AA, 12'h7FF};
    for (int k = 0; k < 4; k++) begin
      host_op(1, adr[k], pat[k], k[0], 0, rd, lat, shw);
      if (k[0]) check(lat == 3, "R5 exact latency after proc slot", lat, 3);
      else      check(lat >= 3 && lat <= 6, "R5 bounded latency", lat, 6);
    end
    for (int k = 0; k < 4; k++) begin
      host_op(0, adr[k], 0, 0, 0, rd, lat, shw);
      check(rd == pat[k], "R1 host readback", rd, pat[k]);
    end
  endtask

  task automatic t_dport();
    host_op(1, 12'h321, 32'hCAFE_F00D, 1, 1, rd, lat, shw);
    host_op(0, 12'h321, 0, 0, 0, rd, lat, shw);
    check(rd == 32'hCAFE_F00D, "R6 late data change ignored", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_prot();
    logic [DW-1:0] pr;
    host_op(1, 12'h0FF, 32'h0000_00FF, 0, 0, rd, lat, shw);
    host_op(1, 12'h100, 32'h0000_0100, 0, 0, rd, lat, shw);
    proc_op(1, 12'h0FF, 32'hBAD0_00FF, pr);
    proc_op(1, 12'h100, 32'h600D_0100, pr);
    host_op(0, 12'h0FF, 0, 0, 0, rd, lat, shw);
    check(rd == 32'h0000_00FF, "R3 protected word unchanged", rd, 32'h0000_00FF);
    host_op(0, 12'h100, 0, 0, 0, rd, lat, shw);
    check(rd == 32'h600D_0100, "R3 word above region written", rd, 32'h600D_0100);
  endtask

  task automatic t_proc_read();
    logic [DW-1:0] pr;
    host_op(1, 12'h444, 32'h4444_ABCD, 0, 0, rd, lat, shw);
    proc_op(0, 12'h444, 0, pr);
    check(pr == 32'h4444_ABCD, "R10 proc read data", pr, 32'h4444_ABCD);
  endtask

  task automatic t_shadow();
    logic [DW-1:0] pr;
    proc_op(1, 12'hFF3, 32'h7777_0FF3, pr);
    host_op(1, 12'hFF3, 32'h5EED_0003, 0, 0, rd, lat, shw);
    check(shw, "R4 shadow write strobe", shw, 1);
    proc_op(0, 12'hFF3, 0, pr);
    check(pr == 32'h7777_0FF3, "R4 shadow write misses RAM", pr, 32'h7777_0FF3);
    host_op(0, 12'hFF3, 0, 0, 0, rd, lat, shw);
    check(rd == 32'hC0DE_5A5A, "R4 shadow read data", rd, 32'hC0DE_5A5A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_boot();
    t_slots();
    t_host_rw();
    t_dport();
    t_prot();
    t_proc_read();
    t_shadow();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule